// File: doc/BRIEF.md
# Serial Baud Tick Generator

This block derives the two timing strobes that an asynchronous serial port needs from its bus-rate clock. A 13-bit divisor sets a modulo counter, which raises a one-cycle sampling strobe every `divisor` clock cycles. This strobe runs at sixteen times the line rate and is meant for the receiver's bit sampling. A fixed divide-by-16 stage counts those strobes and raises a one-cycle bit strobe on every sixteenth one, which gives the transmitter its bit cadence. The line rate is therefore clock / (divisor × 16). Both directions of the port share this one generator.

A divisor of zero stops the generator, and both strobes then stay low. The divisor is a level input that the block registers internally. On any clock edge where the input differs from the registered copy, both counters restart from zero and the new value is captured. As a result, a period that was in progress under the old value never leaks into the new rate.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `samp_tick` and `bit_tick` are both 0. After release, the block treats its stored divisor as zero, so the first edge with a non-zero `divisor` acts as a reload edge (see R6).
- R2: When `divisor` is 0 at a clock edge, both strobes are 0 in the following cycle, and no strobe appears for as long as it stays 0.
- R3: With a steady divisor D ≥ 2, `samp_tick` is high for exactly one cycle in every D cycles.
- R4: With a steady divisor of 1, `samp_tick` is high on every cycle once the reload edge has passed.
- R5: `bit_tick` rises on every sixteenth `samp_tick`, in the same cycle as that strobe, so its period is 16·D cycles.
- R6: Counting the edge at which a changed `divisor` is first seen as edge 1, both strobes are 0 after edge 1. `samp_tick` is then high after edges 1 + k·D, and `bit_tick` is high after edges 1 + 16·k·D, for k ≥ 1.
- R7: Every value from 1 to 8191 is a valid divisor. The largest, 8191, yields a sampling period of 8191 cycles.
- R8: `bit_tick` is never high in a cycle where `samp_tick` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| divisor | input | 13 | Modulo divisor; 0 turns the generator off |
| samp_tick | output | 1 | One-cycle strobe at 16× the line rate |
| bit_tick | output | 1 | One-cycle strobe at the line rate |

## Verification
Both strobes come from registers, so a divisor change seen at one edge shows as low strobes right after that edge. The first sampling strobe follows D edges later, and the first bit strobe follows 16·D edges later. The bench drives `divisor` on a falling edge and numbers each later rising edge from 1, starting at the reload edge. It samples at the next falling edge and compares against the arithmetic schedule of R6, with no slack of any cycle. The sweep covers divisors 1 through 9, 13 and 8191, zero, a change in mid-period, and the first edges after reset.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  parameter int unsigned DEF_DIV_W = 13;
  parameter int unsigned DEF_OVS   = 16;

  typedef struct packed {
    logic reload;
    logic run;
  } div_ctl_t;
endpackage

// File: rtl/baud_div_watch.sv
module baud_div_watch
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_in,
  output logic [DIV_W-1:0] div_q,
  output div_ctl_t         ctl
);
  logic [DIV_W-1:0] div_d;
  logic             differs;

  always_comb begin
    differs    = (div_in != div_q);
    div_d      = div_q;
    if (differs) div_d = div_in;
    ctl.reload = differs;
    ctl.run    = (div_q != '0) && !differs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/baud_mod_counter.sv
module baud_mod_counter
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  div_ctl_t         ctl,
  output logic             samp_evt,
  output logic             samp_tick
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  always_comb begin
    at_last  = (cnt_q == (div_q - ONE));
    samp_evt = ctl.run && at_last;
    cnt_d    = cnt_q;
    if (ctl.reload)   cnt_d = '0;
    else if (ctl.run) cnt_d = at_last ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      samp_tick <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      samp_tick <= samp_evt;
    end
  end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
  import baud_tick_pkg::*;
#(
  parameter int unsigned OVS = DEF_OVS
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_ctl_t ctl,
  input  logic     samp_evt,
  output logic     bit_tick
);
  generate
    if (OVS <= 1) begin : g_pass
      logic unused_reload;
      assign unused_reload = ctl.reload ^ ctl.run;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_tick <= 1'b0;
        else        bit_tick <= samp_evt;
      end
    end else begin : g_div
      localparam int unsigned PRE_W = $clog2(OVS);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(OVS - 1);
      localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);

      logic [PRE_W-1:0] pre_q, pre_d;
      logic             bit_d;
      logic             unused_run;
      assign unused_run = ctl.run;

      always_comb begin
        pre_d = pre_q;
        bit_d = 1'b0;
        if (ctl.reload) begin
          pre_d = '0;
        end else if (samp_evt) begin
          bit_d = (pre_q == PRE_LAST);
          pre_d = bit_d ? '0 : pre_q + PRE_ONE;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q    <= '0;
          bit_tick <= 1'b0;
        end else begin
          pre_q    <= pre_d;
          bit_tick <= bit_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W,
  parameter int unsigned OVS   = DEF_OVS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             samp_tick,
  output logic             bit_tick
);
  logic [DIV_W-1:0] div_q;
  div_ctl_t         ctl;
  logic             samp_evt;

  baud_div_watch #(.DIV_W(DIV_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .div_in(divisor), .div_q(div_q), .ctl(ctl)
  );

  baud_mod_counter #(.DIV_W(DIV_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .ctl(ctl),
    .samp_evt(samp_evt), .samp_tick(samp_tick)
  );

  baud_prescale #(.OVS(OVS)) u_pre (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .samp_evt(samp_evt), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] divisor,
  input logic             samp_tick,
  input logic             bit_tick
);
  p_zero_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> (!samp_tick && !bit_tick));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && (divisor > 1) && $stable(divisor)) |=> !samp_tick);

  p_every_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_tick && (divisor == 1) && $stable(divisor)) |=> samp_tick);

  p_change_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != $past(divisor)) |=> (!samp_tick && !bit_tick));

  p_bit_with_samp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> samp_tick);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor),
  .samp_tick(samp_tick), .bit_tick(bit_tick)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] divisor;
  logic        samp_tick, bit_tick;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .divisor(divisor),
    .samp_tick(samp_tick), .bit_tick(bit_tick)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Edge 1 is the first rising edge after the stimulus; sample after each edge.
  task automatic follow(input int d, input int cycles);
    for (int i = 1; i <= cycles; i++) begin
      logic es, eb;
      @(negedge clk);
      es = (d != 0) && (i > 1) && (((i - 1) % d) == 0);
      eb = (d != 0) && (i > 1) && (((i - 1) % (16 * d)) == 0);
      if (i == 1) begin
        chk("R6 samp on reload", samp_tick, 1'b0);
        chk("R6 bit on reload", bit_tick, 1'b0);
      end else if (d == 0) begin
        chk("R2 samp off", samp_tick, 1'b0);
        chk("R2 bit off", bit_tick, 1'b0);
      end else begin
        chk(d == 8191 ? "R7 samp" : (d == 1 ? "R4 samp" : "R3 samp"), samp_tick, es);
        chk("R5 bit", bit_tick, eb);
      end
      chk("R8 bit without samp", bit_tick & ~samp_tick, 1'b0);
    end
  endtask

  task automatic run_div(input int d, input int cycles);
    @(negedge clk);
    divisor = 13'(d);
    follow(d, cycles);
  endtask

  initial begin
    rst_n   = 1'b0;
    divisor = 13'd4;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 samp in reset", samp_tick, 1'b0);
      chk("R1 bit in reset", bit_tick, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    follow(4, 16 * 4 * 2 + 3);
    for (int d = 1; d <= 9; d++) run_div(d, 16 * d * 2 + 3);
    run_div(0, 200);
    run_div(13, 16 * 13 + 5);
    run_div(6, 10);
    run_div(3, 16 * 3 * 2 + 3);
    run_div(8191, 2 * 8191 + 3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule